// File: doc/BRIEF.md
# Register File with Partial-Width Views

This block holds a bank of general-purpose registers for a small processor datapath. Two read ports and one write port share the bank. Each port carries a register index and a two-bit part selector. The selector chooses one view of the register: the whole word, the low half, the low byte, or the second byte. Reads hand back the chosen field, shifted down to bit 0 and padded with zeros. A write of a narrow field replaces only that field, and the remaining bits of the register keep their value.

Only the lower group of registers offers byte views. A byte request to any other register is treated as illegal. On an illegal request the write does not happen, the read returns zero, and a combinational error flag is high for that cycle. Reads are combinational. A read of the register being written in the same cycle returns the value from before the clock edge. The bank is sized by parameters, and the defaults give eight 32-bit registers, four of which have byte views.

Top module: `rfsw_top`

## Requirements
- R1: A synchronous active-high reset clears every register to zero at the next rising clock edge.
- R2: The part selector encodes 2'b00 = whole word, 2'b01 = bits [15:0], 2'b10 = bits [7:0], 2'b11 = bits [15:8]. A read returns the chosen field placed at bit 0 and zero-extended to the full width.
- R3: A narrow write takes its field from the low bits of the write data (wr_data[15:0] for the half view, wr_data[7:0] for either byte view). It changes only the selected bits of the addressed register on the rising edge.
- R4: Byte views (selector 2'b10 or 2'b11) are legal only for registers 0 to 3. A byte write to registers 4 to 7 is suppressed and leaves every register unchanged.
- R5: A byte read of registers 4 to 7 returns zero on that port.
- R6: The output access_err is high in exactly those cycles that hold an illegal read on either port or an illegal write with wr_en high.
- R7: Reads are combinational. A read of the register being written returns the old value until the rising edge, and the new value after it.
- R8: A write changes only the addressed register, and no register changes while wr_en is low.
- R9: The two read ports are independent. Each returns its own register and view in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Register to write |
| wr_part | input | 2 | View of the write (R2 encoding) |
| wr_data | input | 32 | Write data, narrow fields taken from the low bits |
| rd0_idx | input | 3 | Register read on port 0 |
| rd0_part | input | 2 | View read on port 0 |
| rd0_data | output | 32 | Zero-extended field from port 0 |
| rd1_idx | input | 3 | Register read on port 1 |
| rd1_part | input | 2 | View read on port 1 |
| rd1_data | output | 32 | Zero-extended field from port 1 |
| access_err | output | 1 | High while any current request is illegal |

## Verification
The bench builds the block with its default parameters: eight 32-bit registers, the first four with byte views. With these values the boundary between registers 3 and 4 can be reached, so byte writes and reads are exercised on both sides of it. The upper 16 bits of the word are also present, so the bench can show that half and byte writes leave them untouched. The table walk builds up one register through overlapping narrow writes and reads each view back. Directed steps then cover the read-before-write case, the two ports used at once, an illegal read on the second port, and a reset applied mid-run.

// File: rtl/rfsw_pkg.sv
package rfsw_pkg;

    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PART_WORD = 2'b00,
        PART_HALF = 2'b01,
        PART_LOB  = 2'b10,
        PART_HIB  = 2'b11
    } part_e;

    // Decoded write control for one cycle.
    typedef struct packed {
        logic              legal;
        logic              upper_en;
        logic [HALF_W-1:0] low_mask;
        logic [HALF_W-1:0] low_data;
    } wr_ctl_t;

    function automatic logic is_byte(input part_e p);
        return (p == PART_LOB) || (p == PART_HIB);
    endfunction

    function automatic logic [HALF_W-1:0] low_mask_of(input part_e p);
        case (p)
            PART_LOB: return {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
            PART_HIB: return {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}};
            default:  return {HALF_W{1'b1}};
        endcase
    endfunction

    function automatic logic [HALF_W-1:0] align_wr(input part_e p, input logic [HALF_W-1:0] d);
        if (p == PART_HIB) return {d[BYTE_W-1:0], {BYTE_W{1'b0}}};
        return d;
    endfunction

    function automatic logic [HALF_W-1:0] pick_rd(input part_e p, input logic [HALF_W-1:0] v);
        case (p)
            PART_LOB: return {{BYTE_W{1'b0}}, v[BYTE_W-1:0]};
            PART_HIB: return {{BYTE_W{1'b0}}, v[HALF_W-1:BYTE_W]};
            default:  return v;
        endcase
    endfunction

endpackage

// File: rtl/rfsw_access_chk.sv
module rfsw_access_chk
    import rfsw_pkg::*;
#(
    parameter int NUM_REGS  = 8,
    parameter int BYTE_REGS = 4,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic [IDX_W-1:0] idx,
    input  part_e            part,
    output logic             legal
);
    always_comb begin
        legal = !is_byte(part) || (32'(idx) < BYTE_REGS);
    end
endmodule

// File: rtl/rfsw_read_port.sv
module rfsw_read_port
    import rfsw_pkg::*;
#(
    parameter int NUM_REGS  = 8,
    parameter int DATA_W    = 32,
    parameter int BYTE_REGS = 4,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic [DATA_W-1:0] regs [NUM_REGS],
    input  logic [IDX_W-1:0]  idx,
    input  part_e             part,
    output logic [DATA_W-1:0] data,
    output logic              illegal
);
    logic              legal;
    logic [DATA_W-1:0] sel;

    rfsw_access_chk #(.NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)) u_chk (
        .idx   (idx),
        .part  (part),
        .legal (legal)
    );

    always_comb begin
        sel     = regs[idx];
        illegal = !legal;
        if (!legal) begin
            data = '0;
        end else if (part == PART_WORD) begin
            data = sel;
        end else begin
            data = {{(DATA_W-HALF_W){1'b0}}, pick_rd(part, sel[HALF_W-1:0])};
        end
    end
endmodule

// File: rtl/rfsw_storage.sv
module rfsw_storage
    import rfsw_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_REGS-1:0] we,
    input  wr_ctl_t           ctl,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] regs [NUM_REGS]
);
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (we[r]) begin
                if (ctl.upper_en) begin
                    q[DATA_W-1:HALF_W] <= wr_data[DATA_W-1:HALF_W];
                end
                q[HALF_W-1:0] <= (q[HALF_W-1:0] & ~ctl.low_mask) | (ctl.low_data & ctl.low_mask);
            end
        end
        assign regs[r] = q;
    end
endmodule

// File: rtl/rfsw_top.sv
module rfsw_top
    import rfsw_pkg::*;
#(
    parameter int NUM_REGS  = 8,
    parameter int DATA_W    = 32,
    parameter int BYTE_REGS = 4,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_part,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd0_idx,
    input  logic [1:0]        rd0_part,
    output logic [DATA_W-1:0] rd0_data,
    input  logic [IDX_W-1:0]  rd1_idx,
    input  logic [1:0]        rd1_part,
    output logic [DATA_W-1:0] rd1_data,
    output logic              access_err
);
    initial begin
        if (DATA_W < 2 * HALF_W) $error("DATA_W must be at least 32");
        if (BYTE_REGS > NUM_REGS) $error("BYTE_REGS exceeds NUM_REGS");
    end

    part_e               wr_pe;
    logic                wr_legal;
    logic                rd0_bad;
    logic                rd1_bad;
    wr_ctl_t             ctl;
    logic [NUM_REGS-1:0] we;
    logic [DATA_W-1:0]   regs [NUM_REGS];

    assign wr_pe = part_e'(wr_part);

    rfsw_access_chk #(.NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)) u_wr_chk (
        .idx   (wr_idx),
        .part  (wr_pe),
        .legal (wr_legal)
    );

    always_comb begin
        ctl.legal    = wr_legal;
        ctl.upper_en = (wr_pe == PART_WORD);
        ctl.low_mask = low_mask_of(wr_pe);
        ctl.low_data = align_wr(wr_pe, wr_data[HALF_W-1:0]);
        we           = '0;
        if (wr_en && ctl.legal) we[wr_idx] = 1'b1;
    end

    rfsw_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (we),
        .ctl     (ctl),
        .wr_data (wr_data),
        .regs    (regs)
    );

    rfsw_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .BYTE_REGS(BYTE_REGS)) u_rd0 (
        .regs    (regs),
        .idx     (rd0_idx),
        .part    (part_e'(rd0_part)),
        .data    (rd0_data),
        .illegal (rd0_bad)
    );

    rfsw_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .BYTE_REGS(BYTE_REGS)) u_rd1 (
        .regs    (regs),
        .idx     (rd1_idx),
        .part    (part_e'(rd1_part)),
        .data    (rd1_data),
        .illegal (rd1_bad)
    );

    assign access_err = rd0_bad || rd1_bad || (wr_en && !wr_legal);

    // Port-level checks on illegal byte reads.
    assert_rd0_bad_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (rd0_part[1] && 32'(rd0_idx) >= BYTE_REGS) |-> (rd0_data == '0 && access_err));
    assert_rd1_bad_err_R6: assert property (@(posedge clk) disable iff (rst)
        (rd1_part[1] && 32'(rd1_idx) >= BYTE_REGS) |-> (rd1_data == '0 && access_err));

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_chk
        assert_reset_clear_R1: assert property (@(posedge clk)
            rst |=> (regs[r] == '0));
        assert_untouched_R8: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_idx == IDX_W'(r)) |=> $stable(regs[r]));
        assert_upper_kept_R3: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_idx == IDX_W'(r) && wr_part != 2'b00) |=> $stable(regs[r][DATA_W-1:HALF_W]));
        if (r >= BYTE_REGS) begin : g_nobyte
            assert_byte_wr_blocked_R4: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_idx == IDX_W'(r) && wr_part[1]) |=> $stable(regs[r]));
        end
    end
endmodule

// File: tb/test_rfsw_top.sv
module test_rfsw_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [1:0]  wr_part;
    logic [31:0] wr_data;
    logic [2:0]  rd0_idx;
    logic [1:0]  rd0_part;
    logic [31:0] rd0_data;
    logic [2:0]  rd1_idx;
    logic [1:0]  rd1_part;
    logic [31:0] rd1_data;
    logic        access_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rfsw_top i_rfsw_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_part(wr_part),
        .wr_data(wr_data), .rd0_idx(rd0_idx), .rd0_part(rd0_part), .rd0_data(rd0_data),
        .rd1_idx(rd1_idx), .rd1_part(rd1_part), .rd1_data(rd1_data), .access_err(access_err)
    );

    typedef struct packed {
        logic        we;
        logic [2:0]  wi;
        logic [1:0]  wp;
        logic [31:0] wd;
        logic [2:0]  ri;
        logic [1:0]  rp;
        logic [31:0] exp_d;
        logic        exp_e;
    } vec_t;

    // Write applied at the edge, port 0 read checked after it.
    localparam vec_t VECS [14] = '{
        '{1'b1, 3'd0, 2'b00, 32'h11223344, 3'd0, 2'b00, 32'h11223344, 1'b0}, // R2 word
        '{1'b1, 3'd0, 2'b10, 32'hFFFFFFAA, 3'd0, 2'b00, 32'h112233AA, 1'b0}, // R3 low byte
        '{1'b1, 3'd0, 2'b11, 32'h00000055, 3'd0, 2'b00, 32'h112255AA, 1'b0}, // R3 high byte
        '{1'b1, 3'd0, 2'b01, 32'hFFFFBEEF, 3'd0, 2'b00, 32'h1122BEEF, 1'b0}, // R3 half
        '{1'b0, 3'd0, 2'b00, 32'h0,        3'd0, 2'b11, 32'h000000BE, 1'b0}, // R2 hi read
        '{1'b0, 3'd0, 2'b00, 32'h0,        3'd0, 2'b10, 32'h000000EF, 1'b0}, // R2 lo read
        '{1'b0, 3'd0, 2'b00, 32'h0,        3'd0, 2'b01, 32'h0000BEEF, 1'b0}, // R2 half read
        '{1'b1, 3'd5, 2'b00, 32'hCAFEF00D, 3'd5, 2'b00, 32'hCAFEF00D, 1'b0}, // R2 word r5
        '{1'b1, 3'd5, 2'b01, 32'h00001234, 3'd5, 2'b00, 32'hCAFE1234, 1'b0}, // R3 half r5
        '{1'b1, 3'd5, 2'b10, 32'h00000099, 3'd5, 2'b00, 32'hCAFE1234, 1'b1}, // R4 R6 blocked
        '{1'b0, 3'd0, 2'b00, 32'h0,        3'd5, 2'b11, 32'h00000000, 1'b1}, // R5 R6 bad read
        '{1'b1, 3'd3, 2'b11, 32'h0000007F, 3'd3, 2'b00, 32'h00007F00, 1'b0}, // R3 hi byte r3
        '{1'b1, 3'd7, 2'b00, 32'hFFFFFFFF, 3'd7, 2'b01, 32'h0000FFFF, 1'b0}, // R2 half r7
        '{1'b0, 3'd0, 2'b00, 32'h0,        3'd1, 2'b00, 32'h00000000, 1'b0}  // R8 r1 untouched
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(100_000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_part = '0; wr_data = '0;
        rd0_idx = '0; rd0_part = '0; rd1_idx = 3'd7; rd1_part = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        chk("R1 reset r0", rd0_data, 32'h0);
        chk("R1 reset r7", rd1_data, 32'h0);
        chk("R6 no err", {31'b0, access_err}, 32'h0);
        rd1_idx = 3'd0;

        foreach (VECS[i]) begin
            @(negedge clk);
            wr_en = VECS[i].we; wr_idx = VECS[i].wi; wr_part = VECS[i].wp; wr_data = VECS[i].wd;
            rd0_idx = VECS[i].ri; rd0_part = VECS[i].rp;
            @(posedge clk); #1;
            chk($sformatf("vec %0d data", i), rd0_data, VECS[i].exp_d);
            chk($sformatf("vec %0d R6 err", i), {31'b0, access_err}, {31'b0, VECS[i].exp_e});
        end

        // R7: same-cycle read sees old value, then the new one.
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd2; wr_part = 2'b00; wr_data = 32'hA5A5A5A5;
        rd0_idx = 3'd2; rd0_part = 2'b00;
        #1 chk("R7 old value", rd0_data, 32'h0);
        @(posedge clk); #1;
        chk("R7 new value", rd0_data, 32'hA5A5A5A5);

        // R9: both ports at once; R8: wr_en low keeps r0.
        @(negedge clk);
        wr_en = 1'b0; wr_idx = 3'd0; wr_part = 2'b00; wr_data = 32'h0;
        rd0_idx = 3'd5; rd0_part = 2'b00; rd1_idx = 3'd0; rd1_part = 2'b11;
        @(posedge clk); #1;
        chk("R9 port0", rd0_data, 32'hCAFE1234);
        chk("R9 port1", rd1_data, 32'h000000BE);
        rd0_idx = 3'd0; rd0_part = 2'b00;
        #1 chk("R8 r0 kept", rd0_data, 32'h1122BEEF);

        // R5/R6 on port 1 only.
        @(negedge clk);
        rd1_idx = 3'd5; rd1_part = 2'b10;
        #1 chk("R5 port1 zero", rd1_data, 32'h0);
        chk("R6 port1 err", {31'b0, access_err}, 32'h1);

        // R1: reset mid-run.
        @(negedge clk);
        rd1_idx = 3'd5; rd1_part = 2'b00; rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        chk("R1 mid reset r0", rd0_data, 32'h0);
        chk("R1 mid reset r5", rd1_data, 32'h0);

        done = 1'b1;
        finish_run();
    end
endmodule